// File: doc/BRIEF.md
# Address Filter Setup Frame Generator

This block formats the 192-byte setup frame that a network controller uses to load its perfect-match station address filter. A single start pulse captures a 48-bit station address; the block then streams the whole frame one byte at a time on a valid/ready interface, with flags marking the opening and closing bytes.

The frame is divided into 4-byte slots. Each 16-bit half-word of the station address occupies the two low bytes of one of the first three slots, and the two upper bytes of those slots are padding. Every byte not taken by the address is 0xFF, so the rest of the table holds broadcast or don't-care entries. The block only formats the frame. Submitting it to a descriptor ring and matching received addresses are the job of neighbouring logic.

Top module: `setup_frame_gen`

## Requirements
- R1: After a synchronous active-low reset, `valid_o` and `done_o` are 0. While the block is idle, `valid_o` stays 0 no matter what `ready_i` does.
- R2: When `start_i` is sampled high while idle, `mac_i` is captured on that edge. Streaming begins on the next cycle with `valid_o`=1 and `first_o`=1. Later changes on `mac_i` have no effect on the frame.
- R3: Each frame carries exactly 192 accepted bytes. `last_o` is high only on the byte at offset 191.
- R4: Address byte k is `mac_i[8k+7:8k]`. Bytes 0 and 1 go to offsets 0 and 1, bytes 2 and 3 to offsets 4 and 5, and bytes 4 and 5 to offsets 8 and 9.
- R5: Every other offset, including the padding offsets 2, 3, 6, 7, 10 and 11, carries 0xFF.
- R6: While `valid_o` is 1 and `ready_i` is 0, the same byte and flags are held on the next cycle.
- R7: On the cycle after the byte with `last_o` is accepted, `done_o` is 1 for exactly one cycle and `valid_o` is 0.
- R8: `start_i` is ignored while a frame is being streamed. The frame neither restarts nor takes the new address.
- R9: `first_o` is high only on the byte at offset 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| start_i | input | 1 | Request to build one frame |
| mac_i | input | 48 | Station address, byte k in bits 8k+7:8k |
| ready_i | input | 1 | Sink accepts the current byte |
| valid_o | output | 1 | A frame byte is presented |
| data_o | output | 8 | Frame byte |
| first_o | output | 1 | Byte is at offset 0 |
| last_o | output | 1 | Byte is at offset 191 |
| done_o | output | 1 | One-cycle pulse after the final byte is accepted |

## Verification
If the byte cursor slips, the whole frame shifts. A wrong offset shows up as address bytes landing in padding positions, or as `last_o` arriving at a byte count other than 192, and the first mismatch appears within one accepted byte. A captured address that gets overwritten in mid-frame shows up in the later address slots. Streaming is therefore checked under continuous, alternating and irregular `ready_i` patterns, with a late start pulse and a changing `mac_i`. A stale state register shows up on the cycle after the final byte, as a missing `done_o` pulse or a `valid_o` that stays high.

// File: rtl/sfg_pkg.sv
// Shared constants and types for the setup frame generator.
// Assumes: one byte per beat; the fill value marks unused filter entries.
package sfg_pkg;
    localparam logic [7:0] PAD_BYTE = 8'hFF;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_SEND = 1'b1
    } sfg_state_e;
endpackage

// File: rtl/sfg_cursor.sv
// Frame cursor: tracks the streaming state and the offset of the byte on
// offer, and moves to the next offset on each accepted beat.
// Assumes: launch_i is only acted on while idle; step_i means valid & ready.
module sfg_cursor
    import sfg_pkg::*;
#(
    parameter int FRAME_BYTES = 192,
    parameter int OFS_W       = $clog2(FRAME_BYTES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             launch_i,
    input  logic             step_i,
    output logic             active_o,
    output logic [OFS_W-1:0] ofs_o,
    output logic             first_o,
    output logic             last_o,
    output logic             finish_o
);
    localparam logic [OFS_W-1:0] LAST_OFS = OFS_W'(FRAME_BYTES - 1);

    sfg_state_e       state_q;
    logic [OFS_W-1:0] ofs_q;
    logic             finish_q;

    // State, offset and completion pulse update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q  <= ST_IDLE;
            ofs_q    <= '0;
            finish_q <= 1'b0;
        end else begin
            finish_q <= 1'b0;
            case (state_q)
                ST_IDLE: begin
                    if (launch_i) begin
                        state_q <= ST_SEND;
                        ofs_q   <= '0;
                    end
                end
                ST_SEND: begin
                    if (step_i) begin
                        if (ofs_q == LAST_OFS) begin
                            state_q  <= ST_IDLE;
                            ofs_q    <= '0;
                            finish_q <= 1'b1;
                        end else begin
                            ofs_q <= ofs_q + 1'b1;
                        end
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    // Decoded outputs for the current beat.
    always_comb begin
        active_o = (state_q == ST_SEND);
        ofs_o    = ofs_q;
        first_o  = active_o && (ofs_q == '0);
        last_o   = active_o && (ofs_q == LAST_OFS);
        finish_o = finish_q;
    end

    AST_CURSOR_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        active_o |-> (ofs_q <= LAST_OFS)); // R3
    AST_CURSOR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (active_o && !step_i) |=> (active_o && $stable(ofs_q))); // R6
    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        finish_o |=> !finish_o); // R7
endmodule

// File: rtl/sfg_byte_map.sv
// Byte map: returns the frame byte for a given offset. Each address
// half-word sits in the low two lanes of a slot; all else is padding.
// Assumes: MAC_BYTES is even and SLOT_BYTES is a power of two >= 2.
module sfg_byte_map
    import sfg_pkg::*;
#(
    parameter int FRAME_BYTES = 192,
    parameter int MAC_BYTES   = 6,
    parameter int SLOT_BYTES  = 4,
    parameter int OFS_W       = $clog2(FRAME_BYTES)
) (
    input  logic [OFS_W-1:0]       ofs_i,
    input  logic [8*MAC_BYTES-1:0] mac_i,
    output logic [7:0]             byte_o
);
    localparam int LANES_USED = 2;
    localparam int SLOT_SHIFT = $clog2(SLOT_BYTES);

    logic [OFS_W-1:0]      slot;
    logic [SLOT_SHIFT-1:0] lane;

    // Split the offset into slot index and lane, then pick the byte.
    always_comb begin
        slot   = ofs_i >> SLOT_SHIFT;
        lane   = ofs_i[SLOT_SHIFT-1:0];
        byte_o = PAD_BYTE;
        for (int k = 0; k < MAC_BYTES; k++) begin
            if (slot == OFS_W'(k / LANES_USED) &&
                lane == SLOT_SHIFT'(k % LANES_USED)) begin
                byte_o = mac_i[8*k +: 8];
            end
        end
    end
endmodule

// File: rtl/setup_frame_gen.sv
// Setup frame generator top: captures the station address on start and
// streams the fixed-length filter setup frame on a valid/ready byte port.
// Assumes: the sink may hold ready low for any number of cycles.
module setup_frame_gen
    import sfg_pkg::*;
#(
    parameter int FRAME_BYTES = 192,
    parameter int MAC_BYTES   = 6,
    parameter int SLOT_BYTES  = 4
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   start_i,
    input  logic [8*MAC_BYTES-1:0] mac_i,
    input  logic                   ready_i,
    output logic                   valid_o,
    output logic [7:0]             data_o,
    output logic                   first_o,
    output logic                   last_o,
    output logic                   done_o
);
    localparam int OFS_W     = $clog2(FRAME_BYTES);
    localparam int ADDR_SPAN = (MAC_BYTES / 2) * SLOT_BYTES;

    logic [8*MAC_BYTES-1:0] mac_q;
    logic                   active;
    logic [OFS_W-1:0]       ofs;
    logic                   launch;
    logic                   step;

    assign launch = start_i && !active;
    assign step   = active && ready_i;

    // Capture the station address when a frame is launched.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mac_q <= '0;
        end else if (launch) begin
            mac_q <= mac_i;
        end
    end

    sfg_cursor #(
        .FRAME_BYTES (FRAME_BYTES),
        .OFS_W       (OFS_W)
    ) u_cursor (
        .clk      (clk),
        .rst_n    (rst_n),
        .launch_i (launch),
        .step_i   (step),
        .active_o (active),
        .ofs_o    (ofs),
        .first_o  (first_o),
        .last_o   (last_o),
        .finish_o (done_o)
    );

    sfg_byte_map #(
        .FRAME_BYTES (FRAME_BYTES),
        .MAC_BYTES   (MAC_BYTES),
        .SLOT_BYTES  (SLOT_BYTES),
        .OFS_W       (OFS_W)
    ) u_map (
        .ofs_i  (ofs),
        .mac_i  (mac_q),
        .byte_o (data_o)
    );

    assign valid_o = active;

    AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_o && !ready_i) |=> (valid_o && $stable(data_o) && $stable(last_o))); // R6
    AST_DONE_AFTER_LAST: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_o && ready_i && last_o) |=> (done_o && !valid_o)); // R7
    AST_MAC_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |=> $stable(mac_q)); // R8
    AST_PAD_OUTSIDE: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_o && ofs >= OFS_W'(ADDR_SPAN)) |-> (data_o == PAD_BYTE)); // R5
    AST_FLAG_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(first_o && last_o)); // R9
endmodule

// File: tb/setup_frame_gen_bench.sv
module setup_frame_gen_bench;
    localparam int CLK_PERIOD = 10;
    localparam int NBYTES     = 192;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic [47:0] mac_i = '0;
    logic        ready_i = 1'b0;
    logic        valid_o;
    logic [7:0]  data_o;
    logic        first_o;
    logic        last_o;
    logic        done_o;

    int n_checks = 0;
    int n_fail   = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    setup_frame_gen u_setup_frame_gen (
        .clk     (clk),
        .rst_n   (rst_n),
        .start_i (start_i),
        .mac_i   (mac_i),
        .ready_i (ready_i),
        .valid_o (valid_o),
        .data_o  (data_o),
        .first_o (first_o),
        .last_o  (last_o),
        .done_o  (done_o)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic logic [7:0] exp_byte(input logic [47:0] mac, input int ofs);
        if (ofs < 12 && (ofs % 4) < 2)
            return mac[8*((ofs/4)*2 + ofs%4) +: 8];
        return 8'hFF;
    endfunction

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    endtask

    // Reset state and idle behaviour.
    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        check(valid_o == 1'b0, "R1", "valid in reset", 64'(valid_o), 0);
        check(done_o == 1'b0, "R1", "done in reset", 64'(done_o), 0);
        rst_n   = 1'b1;
        ready_i = 1'b1;
        repeat (5) @(negedge clk);
        check(valid_o == 1'b0, "R1", "valid while idle", 64'(valid_o), 0);
        ready_i = 1'b0;
    endtask

    // One frame: mode 0 ready always, 1 alternating, 2 irregular with a long
    // stall; poke sends a second start mid-frame with a different address.
    task automatic t_frame(input logic [47:0] mac, input int mode, input bit poke);
        logic [7:0] got [NBYTES];
        int         cnt = 0;
        bit         ended = 0;
        bit         prev_stall = 0;
        logic [7:0] prev_data = '0;
        logic [7:0] lfsr = 8'h5A;
        bit         r;
        @(negedge clk);
        mac_i   = mac;
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        mac_i   = ~mac;
        check(valid_o && first_o, "R2", "first beat after start",
              64'({valid_o, first_o}), 64'h3);
        for (int cyc = 0; cyc < 4000 && !ended; cyc++) begin
            if (prev_stall)
                check(valid_o && data_o == prev_data, "R6", "held byte under stall",
                      64'(data_o), 64'(prev_data));
            lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
            if (mode == 0)      r = 1'b1;
            else if (mode == 1) r = (cyc % 2) == 1;
            else                r = (cyc >= 20 && cyc < 32) ? 1'b0 : (lfsr[0] | lfsr[2]);
            ready_i = r;
            if (poke && cnt == 3) begin
                start_i = 1'b1;
                mac_i   = 48'h0;
            end else begin
                start_i = 1'b0;
            end
            if (valid_o && ready_i) begin
                if (cnt < NBYTES) got[cnt] = data_o;
                if (first_o != (cnt == 0))
                    check(1'b0, "R9", "first flag position", 64'(cnt), 0);
                if (last_o) begin
                    ended = 1;
                    check(cnt == NBYTES - 1, "R3", "last flag offset", 64'(cnt), NBYTES - 1);
                end
                cnt++;
            end
            prev_stall = valid_o && !ready_i;
            prev_data  = data_o;
            @(negedge clk);
        end
        start_i = 1'b0;
        ready_i = 1'b0;
        check(done_o && !valid_o, "R7", "done after last", 64'({done_o, valid_o}), 64'h2);
        @(negedge clk);
        check(!done_o, "R7", "done lasts one cycle", 64'(done_o), 0);
        check(cnt == NBYTES, "R3", "frame length", 64'(cnt), NBYTES);
        for (int i = 0; i < NBYTES && i < cnt; i++) begin
            if (i < 12 && (i % 4) < 2)
                check(got[i] == exp_byte(mac, i), "R4", $sformatf("address byte at %0d", i),
                      64'(got[i]), 64'(exp_byte(mac, i)));
            else
                check(got[i] == 8'hFF, "R5", $sformatf("pad byte at %0d", i),
                      64'(got[i]), 64'hFF);
        end
        if (poke && cnt == NBYTES)
            check(got[8] == mac[39:32] && got[9] == mac[47:40], "R8",
                  "late start left address intact", 64'({got[8], got[9]}),
                  64'({mac[39:32], mac[47:40]}));
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        check(1'b0, "R7", "watchdog expired", 150000, 0);
        finish_run();
    end

    initial begin
        t_reset();
        t_frame(48'h665544332211, 0, 1'b0);
        t_frame(48'hA5B4C3D2E1F0, 1, 1'b0);
        t_frame(48'h0123456789AB, 2, 1'b1);
        t_frame(48'hFEDCBA987654, 0, 1'b1);
        finish_run();
    end
endmodule